// File: doc/BRIEF.md
# Translation table update engine

This block carries out maintenance commands against a set of I/O address translation tables. A command names a table by its identifier, gives an I/O bus address, and carries either an entry value or the address of an entry list in memory, along with a page count. Four kinds exist: writing one entry, reading one entry back, filling a run of consecutive pages with a single value, and copying a run of entries from a list held in memory into consecutive pages. Each command finishes with a one-cycle done pulse and a status bit that reports success or a parameter error. A read also returns the stored entry.

The tables live outside the block. The engine drives their write port and addresses their read port. It fetches list words through a simple 64-bit request/acknowledge read port. Each table has its own identifier, bus base address and entry count, supplied as static configuration inputs. The page size is a parameter. A command is accepted whenever the engine is idle. It then holds busy until its done pulse. A multi-page command handles one page per clock, and a list copy also waits for each memory read.

Top module: `tte_update_engine`

## Requirements
- R1: During and right after reset, busy and done are low, status is 1 (parameter error), and neither the table write enable nor the memory request is asserted.
- R2: A put (cmd_op 0) clears the low PAGE_SHIFT bits of the address, subtracts the table's bus base and shifts right by PAGE_SHIFT to form the entry index. It stores cmd_arg unchanged, permission bits included, and reports status 0 with done two clocks after acceptance.
- R3: When the index is at or beyond the table's entry count, the command reports status 1 and writes nothing. This includes an address below the bus base, where the subtraction wraps.
- R4: A command whose identifier matches no configured table reports status 1 in the clock after acceptance and touches neither the tables nor memory.
- R5: A get (cmd_op 1) with an in-range index places the stored entry on get_data with status 0. A failing get leaves get_data at its previous value.
- R6: A stuff (cmd_op 2) writes cmd_arg into cmd_pages consecutive entries, one per clock, starting at the computed index. When every page succeeds, done follows cmd_pages+1 clocks after acceptance.
- R7: A stuff whose page count is zero or larger than the table's entry count reports status 1 without writing.
- R8: A multi-page command stops at the first page whose index is out of range and reports status 1. Entries written before that page keep their new values.
- R9: A list put (cmd_op 3) writes into page i the 64-bit word read from (cmd_arg with its low two bits cleared) + 8·i. Each memory request holds its address until it is acknowledged.
- R10: A list put reports status 1 with no memory request and no write when the page count is zero, exceeds LIST_MAX (512), or cmd_arg has any of its low LIST_ALIGN (12) bits set.
- R11: With several tables configured, a command uses the bus base and entry count of the lowest-numbered table whose identifier matches. Writes and reads go to that table's select value.
- R12: busy stays high from the clock after acceptance through the done clock. done lasts one clock, and busy is low in the clock after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_op | input | 2 | 0 put, 1 get, 2 stuff, 3 list put |
| cmd_tbl_id | input | IDW | Table identifier |
| cmd_addr | input | AW | I/O bus address of the first page |
| cmd_arg | input | EW | Entry value, or list address for a list put |
| cmd_pages | input | CNTW | Page count for stuff and list put |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |
| status | output | 1 | 0 success, 1 parameter error |
| get_data | output | EW | Entry returned by the last successful get |
| cfg_tbl_id | input | NUM_TABLES·IDW | Identifier of each table |
| cfg_bus_base | input | NUM_TABLES·AW | Bus base address of each table |
| cfg_tbl_size | input | NUM_TABLES·clog2(MAX_ENTRIES+1) | Entry count of each table |
| tw_en | output | 1 | Table write enable |
| tw_sel | output | max(1,clog2(NUM_TABLES)) | Table written |
| tw_idx | output | clog2(MAX_ENTRIES) | Entry written |
| tw_data | output | EW | Entry value written |
| tr_sel | output | max(1,clog2(NUM_TABLES)) | Table read |
| tr_idx | output | clog2(MAX_ENTRIES) | Entry read |
| tr_data | input | EW | Combinational read data from the table |
| mem_req | output | 1 | List word read request |
| mem_addr | output | AW | List word address |
| mem_ack | input | 1 | Read complete, mem_data valid |
| mem_data | input | 64 | List word |

## Verification
The testbench uses two small tables, one with a zero bus base and one with a nonzero base, and sweeps puts and gets across every index plus a few beyond the end. The sweep addresses carry nonzero low bits, which shows that alignment and base subtraction take place before the bound test. Stuff runs of several start/length pairs separate one-page-per-clock progress from early termination. Runs that cross the table end show which entries survive a stop. List copies run through a memory model with latency. They are checked by deriving each written word from its address, which exposes wrong strides or a missing low-bit clear. The rejected forms (zero count, oversize count, misaligned list, unknown identifier) are told apart from accepted ones by done timing and by the absence of writes and fetches.

// File: rtl/tte_pkg.sv
package tte_pkg;

   typedef enum logic [1:0] {
      OP_PUT   = 2'd0,
      OP_GET   = 2'd1,
      OP_STUFF = 2'd2,
      OP_LIST  = 2'd3
   } tte_op_e;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_STEP  = 2'd1,
      S_FETCH = 2'd2,
      S_DONE  = 2'd3
   } tte_state_e;

   localparam logic ST_OK    = 1'b0;
   localparam logic ST_PARAM = 1'b1;

endpackage

// File: rtl/tte_table_match.sv
module tte_table_match #(
   parameter int NUM_TABLES = 2,
   parameter int IDW        = 32,
   parameter int SELW       = 1
) (
   input  logic [NUM_TABLES*IDW-1:0] cfg_id,
   input  logic [IDW-1:0]            cmd_id,
   output logic                      hit,
   output logic [SELW-1:0]           sel
);

   logic [NUM_TABLES-1:0] eq;

   generate
      for (genvar t = 0; t < NUM_TABLES; t++) begin : g_cmp
         assign eq[t] = (cfg_id[t*IDW +: IDW] == cmd_id);
      end
   endgenerate

   // lowest numbered match wins: scan from the top down
   always_comb begin
      sel = '0;
      for (int t = NUM_TABLES - 1; t >= 0; t--) begin
         if (eq[t]) sel = SELW'(t);
      end
   end

   assign hit = |eq;

endmodule

// File: rtl/tte_index_calc.sv
module tte_index_calc #(
   parameter int AW         = 64,
   parameter int PAGE_SHIFT = 12,
   parameter int NUM_TABLES = 2,
   parameter int SELW       = 1,
   parameter int PIW        = AW - PAGE_SHIFT
) (
   input  logic [AW-1:0]            addr,
   input  logic [NUM_TABLES*AW-1:0] cfg_base,
   input  logic [SELW-1:0]          sel,
   output logic [PIW-1:0]           page_idx
);

   logic [AW-1:0] base;
   logic [AW-1:0] aligned;
   logic [AW-1:0] rel;

   generate
      if (NUM_TABLES == 1) begin : g_one_base
         assign base = cfg_base[AW-1:0];
      end else begin : g_mux_base
         assign base = cfg_base[sel*AW +: AW];
      end

      if (PAGE_SHIFT == 0) begin : g_byte_pages
         assign aligned = addr;
      end else begin : g_paged
         assign aligned = {addr[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
      end
   endgenerate

   // wraps when the address lies below the base, landing far out of range
   assign rel      = aligned - base;
   assign page_idx = rel[AW-1:PAGE_SHIFT];

endmodule

// File: rtl/tte_precheck.sv
module tte_precheck
   import tte_pkg::*;
#(
   parameter int AW         = 64,
   parameter int CNTW       = 16,
   parameter int ENTW       = 7,
   parameter int LIST_MAX   = 512,
   parameter int LIST_ALIGN = 12
) (
   input  tte_op_e         op,
   input  logic            hit,
   input  logic [CNTW-1:0] count,
   input  logic [AW-1:0]   list_addr,
   input  logic [ENTW-1:0] entries,
   output logic            ok
);

   logic list_aligned;
   logic over_list;
   logic over_table;
   logic zero_cnt;

   generate
      if (LIST_ALIGN == 0) begin : g_no_align
         assign list_aligned = 1'b1;
      end else begin : g_align
         assign list_aligned = (list_addr[LIST_ALIGN-1:0] == '0);
      end
   endgenerate

   assign over_list  = 32'(count) > 32'(LIST_MAX);
   assign over_table = 32'(count) > 32'(entries);
   assign zero_cnt   = (count == '0);

   always_comb begin
      unique case (op)
         OP_STUFF: ok = hit && !zero_cnt && !over_table;
         OP_LIST:  ok = hit && !zero_cnt && !over_list && list_aligned;
         default:  ok = hit;
      endcase
   end

endmodule

// File: rtl/tte_update_engine.sv
module tte_update_engine
   import tte_pkg::*;
#(
   parameter int AW          = 64,
   parameter int EW          = 64,
   parameter int IDW         = 32,
   parameter int CNTW        = 16,
   parameter int NUM_TABLES  = 2,
   parameter int MAX_ENTRIES = 64,
   parameter int PAGE_SHIFT  = 12,
   parameter int LIST_MAX    = 512,
   parameter int LIST_ALIGN  = 12
) (
   input  logic                                              clk,
   input  logic                                              rst_n,
   input  logic                                              cmd_valid,
   input  logic [1:0]                                        cmd_op,
   input  logic [IDW-1:0]                                    cmd_tbl_id,
   input  logic [AW-1:0]                                     cmd_addr,
   input  logic [EW-1:0]                                     cmd_arg,
   input  logic [CNTW-1:0]                                   cmd_pages,
   output logic                                              busy,
   output logic                                              done,
   output logic                                              status,
   output logic [EW-1:0]                                     get_data,
   input  logic [NUM_TABLES*IDW-1:0]                         cfg_tbl_id,
   input  logic [NUM_TABLES*AW-1:0]                          cfg_bus_base,
   input  logic [NUM_TABLES*$clog2(MAX_ENTRIES+1)-1:0]       cfg_tbl_size,
   output logic                                              tw_en,
   output logic [((NUM_TABLES>1)?$clog2(NUM_TABLES):1)-1:0]  tw_sel,
   output logic [$clog2(MAX_ENTRIES)-1:0]                    tw_idx,
   output logic [EW-1:0]                                     tw_data,
   output logic [((NUM_TABLES>1)?$clog2(NUM_TABLES):1)-1:0]  tr_sel,
   output logic [$clog2(MAX_ENTRIES)-1:0]                    tr_idx,
   input  logic [EW-1:0]                                     tr_data,
   output logic                                              mem_req,
   output logic [AW-1:0]                                     mem_addr,
   input  logic                                              mem_ack,
   input  logic [63:0]                                       mem_data
);

   localparam int SELW = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1;
   localparam int IDXW = $clog2(MAX_ENTRIES);
   localparam int ENTW = $clog2(MAX_ENTRIES + 1);
   localparam int PIW  = AW - PAGE_SHIFT;
   localparam int STEP_BYTES = 8;

   initial begin
      assert (EW >= AW && EW == 64) else $error("entry width must be 64 and cover the address");
      assert (PIW > ENTW) else $error("page index narrower than entry count");
      assert (CNTW <= 32) else $error("page count wider than 32 bits");
      assert (LIST_ALIGN < AW && LIST_ALIGN >= 2) else $error("list alignment out of range");
      assert (MAX_ENTRIES >= 2) else $error("tables need at least two entries");
      assert (NUM_TABLES >= 1) else $error("no tables configured");
   end

   tte_state_e          state;
   tte_op_e             op_q;
   tte_op_e             op_in;
   logic [SELW-1:0]     sel_q;
   logic [PIW-1:0]      idx_q;
   logic [EW-1:0]       val_q;
   logic [AW-1:0]       lptr_q;
   logic [CNTW-1:0]     left_q;
   logic                stat_q;
   logic [EW-1:0]       get_q;

   logic                hit;
   logic [SELW-1:0]     sel_new;
   logic [PIW-1:0]      pidx_new;
   logic                pre_ok;
   logic [ENTW-1:0]     ent_new;
   logic [ENTW-1:0]     ent_cur;
   logic                in_range;
   logic                last_page;

   assign op_in = tte_op_e'(cmd_op);

   tte_table_match #(
      .NUM_TABLES (NUM_TABLES),
      .IDW        (IDW),
      .SELW       (SELW)
   ) u_match (
      .cfg_id (cfg_tbl_id),
      .cmd_id (cmd_tbl_id),
      .hit    (hit),
      .sel    (sel_new)
   );

   tte_index_calc #(
      .AW         (AW),
      .PAGE_SHIFT (PAGE_SHIFT),
      .NUM_TABLES (NUM_TABLES),
      .SELW       (SELW),
      .PIW        (PIW)
   ) u_index (
      .addr     (cmd_addr),
      .cfg_base (cfg_bus_base),
      .sel      (sel_new),
      .page_idx (pidx_new)
   );

   assign ent_new = cfg_tbl_size[sel_new*ENTW +: ENTW];
   assign ent_cur = cfg_tbl_size[sel_q*ENTW +: ENTW];

   tte_precheck #(
      .AW         (AW),
      .CNTW       (CNTW),
      .ENTW       (ENTW),
      .LIST_MAX   (LIST_MAX),
      .LIST_ALIGN (LIST_ALIGN)
   ) u_pre (
      .op        (op_in),
      .hit       (hit),
      .count     (cmd_pages),
      .list_addr (cmd_arg[AW-1:0]),
      .entries   (ent_new),
      .ok        (pre_ok)
   );

   // bound test on the full-width index so wrapped addresses fail
   assign in_range  = idx_q < PIW'(ent_cur);
   assign last_page = (left_q == CNTW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         op_q   <= OP_PUT;
         sel_q  <= '0;
         idx_q  <= '0;
         val_q  <= '0;
         lptr_q <= '0;
         left_q <= '0;
         stat_q <= ST_PARAM;
         get_q  <= '0;
      end else begin
         unique case (state)
            S_IDLE: begin
               if (cmd_valid) begin
                  op_q   <= op_in;
                  sel_q  <= sel_new;
                  idx_q  <= pidx_new;
                  val_q  <= cmd_arg;
                  lptr_q <= {cmd_arg[AW-1:2], 2'b00};
                  left_q <= cmd_pages;
                  if (!pre_ok) begin
                     stat_q <= ST_PARAM;
                     state  <= S_DONE;
                  end else if (op_in == OP_LIST) begin
                     state  <= S_FETCH;
                  end else begin
                     state  <= S_STEP;
                  end
               end
            end
            S_STEP: begin
               if (!in_range) begin
                  stat_q <= ST_PARAM;
                  state  <= S_DONE;
               end else begin
                  unique case (op_q)
                     OP_GET: begin
                        get_q  <= tr_data;
                        stat_q <= ST_OK;
                        state  <= S_DONE;
                     end
                     OP_STUFF: begin
                        idx_q  <= idx_q + PIW'(1);
                        left_q <= left_q - CNTW'(1);
                        if (last_page) begin
                           stat_q <= ST_OK;
                           state  <= S_DONE;
                        end
                     end
                     default: begin
                        stat_q <= ST_OK;
                        state  <= S_DONE;
                     end
                  endcase
               end
            end
            S_FETCH: begin
               if (!in_range) begin
                  stat_q <= ST_PARAM;
                  state  <= S_DONE;
               end else if (mem_ack) begin
                  idx_q  <= idx_q + PIW'(1);
                  lptr_q <= lptr_q + AW'(STEP_BYTES);
                  left_q <= left_q - CNTW'(1);
                  if (last_page) begin
                     stat_q <= ST_OK;
                     state  <= S_DONE;
                  end
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy     = (state != S_IDLE);
   assign done     = (state == S_DONE);
   assign status   = stat_q;
   assign get_data = get_q;

   assign tw_en   = in_range && (((state == S_STEP) && (op_q != OP_GET)) ||
                                 ((state == S_FETCH) && mem_ack));
   assign tw_sel  = sel_q;
   assign tw_idx  = idx_q[IDXW-1:0];
   assign tw_data = (state == S_FETCH) ? mem_data : val_q;
   assign tr_sel  = sel_q;
   assign tr_idx  = idx_q[IDXW-1:0];

   assign mem_req  = (state == S_FETCH) && in_range;
   assign mem_addr = lptr_q;

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12
   idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R6
   page_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tw_en && $past(tw_en)) |-> (tw_idx == $past(tw_idx) + IDXW'(1)));

   // R3
   write_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tw_en |-> (32'(tw_idx) < 32'(ent_cur)));

   // R10
   reject_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !$past(busy)) |-> !$past(mem_req));

endmodule

// File: tb/sim_tte_update_engine.sv
module sim_tte_update_engine;

   localparam int NT   = 2;
   localparam int ME   = 16;
   localparam int AW   = 64;
   localparam int EW   = 64;
   localparam int IDW  = 32;
   localparam int CNTW = 16;
   localparam int ENTW = 5;
   localparam int LAT  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic            cmd_valid = 1'b0;
   logic [1:0]      cmd_op = '0;
   logic [IDW-1:0]  cmd_tbl_id = '0;
   logic [AW-1:0]   cmd_addr = '0;
   logic [EW-1:0]   cmd_arg = '0;
   logic [CNTW-1:0] cmd_pages = '0;
   logic            busy, done, status;
   logic [EW-1:0]   get_data;
   logic [NT*IDW-1:0]  cfg_id   = {32'h0000_0022, 32'h0000_0010};
   logic [NT*AW-1:0]   cfg_base = {64'h0000_0000_0010_0000, 64'h0};
   logic [NT*ENTW-1:0] cfg_sz   = {5'd8, 5'd16};
   logic            tw_en;
   logic [0:0]      tw_sel, tr_sel;
   logic [3:0]      tw_idx, tr_idx;
   logic [EW-1:0]   tw_data, tr_data;
   logic            mem_req;
   logic [AW-1:0]   mem_addr;
   logic            mem_ack = 1'b0;
   logic [63:0]     mem_data = '0;

   logic [EW-1:0] tbl   [NT][ME];
   logic [EW-1:0] exp_t [NT][ME];
   logic [EW-1:0] last_get = '0;
   int wr_cnt = 0;
   int fetch_cnt = 0;
   int lat_cnt = 0;
   int checks = 0;
   int fails = 0;

   tte_update_engine #(
      .AW(AW), .EW(EW), .IDW(IDW), .CNTW(CNTW), .NUM_TABLES(NT),
      .MAX_ENTRIES(ME), .PAGE_SHIFT(12), .LIST_MAX(512), .LIST_ALIGN(12)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_tbl_id(cmd_tbl_id), .cmd_addr(cmd_addr), .cmd_arg(cmd_arg),
      .cmd_pages(cmd_pages), .busy(busy), .done(done), .status(status),
      .get_data(get_data), .cfg_tbl_id(cfg_id), .cfg_bus_base(cfg_base),
      .cfg_tbl_size(cfg_sz), .tw_en(tw_en), .tw_sel(tw_sel), .tw_idx(tw_idx),
      .tw_data(tw_data), .tr_sel(tr_sel), .tr_idx(tr_idx), .tr_data(tr_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_data(mem_data)
   );

   function automatic logic [63:0] memval(input logic [63:0] a);
      return (a * 64'd2654435761) ^ 64'hC3C3_5A5A_0000_0001;
   endfunction

   assign tr_data = tbl[tr_sel][tr_idx];

   always @(posedge clk) begin
      if (tw_en) begin
         tbl[tw_sel][tw_idx] <= tw_data;
         wr_cnt <= wr_cnt + 1;
      end
      if (mem_req && mem_ack) fetch_cnt <= fetch_cnt + 1;
   end

   // list memory with a fixed response latency, driven off the falling edge
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack <= 1'b0;
         lat_cnt <= 0;
      end else if (mem_req) begin
         if (lat_cnt == LAT) begin
            mem_ack  <= 1'b1;
            mem_data <= memval(mem_addr);
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic run(input int op, input logic [31:0] id, input logic [63:0] addr,
                      input logic [63:0] arg, input int pages, input string tag);
      int t, ent, exp_cyc, exp_wr, exp_fetch, cyc, wr0, fe0, bad;
      bit exp_stat, busy_ok;
      logic [63:0] base, ix;
      t = -1;
      for (int k = NT - 1; k >= 0; k--)
         if (cfg_id[k*IDW +: IDW] == id) t = k;
      exp_wr = 0; exp_fetch = 0; exp_stat = 1'b1; exp_cyc = 1;
      if (t >= 0) begin
         base = cfg_base[t*AW +: AW];
         ent  = int'(cfg_sz[t*ENTW +: ENTW]);
         ix   = ((addr & ~64'hFFF) - base) >> 12;
         case (op)
            0: begin
               exp_cyc = 2;
               if (ix < 64'(ent)) begin
                  exp_t[t][ix[3:0]] = arg; exp_stat = 1'b0; exp_wr = 1;
               end
            end
            1: begin
               exp_cyc = 2;
               if (ix < 64'(ent)) begin
                  last_get = exp_t[t][ix[3:0]]; exp_stat = 1'b0;
               end
            end
            2: begin
               if (pages != 0 && pages <= ent) begin
                  exp_stat = 1'b0; exp_cyc = pages + 1;
                  for (int i = 0; i < pages; i++) begin
                     if (ix + 64'(i) >= 64'(ent)) begin
                        exp_stat = 1'b1; exp_cyc = i + 2; break;
                     end
                     exp_t[t][ix[3:0] + 4'(i)] = arg; exp_wr++;
                  end
               end
            end
            default: begin
               if (pages != 0 && pages <= 512 && arg[11:0] == 12'h0) begin
                  exp_stat = 1'b0; exp_cyc = -1;
                  for (int i = 0; i < pages; i++) begin
                     if (ix + 64'(i) >= 64'(ent)) begin
                        exp_stat = 1'b1; break;
                     end
                     exp_t[t][ix[3:0] + 4'(i)] = memval((arg & ~64'h3) + 64'(8 * i));
                     exp_wr++; exp_fetch++;
                  end
               end
            end
         endcase
      end
      wr0 = wr_cnt; fe0 = fetch_cnt;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'(op); cmd_tbl_id = id; cmd_addr = addr;
      cmd_arg = arg; cmd_pages = CNTW'(pages);
      @(negedge clk);
      cmd_valid = 1'b0;
      cyc = 1; busy_ok = 1'b1;
      while (!done && cyc < 3000) begin
         if (!busy) busy_ok = 1'b0;
         @(negedge clk);
         cyc++;
      end
      if (!busy) busy_ok = 1'b0;
      chk(status == exp_stat, {tag, " status"}, 64'(status), 64'(exp_stat));
      if (exp_cyc >= 0) chk(cyc == exp_cyc, {tag, " done timing"}, 64'(cyc), 64'(exp_cyc));
      if (op == 1) chk(get_data == last_get, {tag, " get_data"}, get_data, last_get);
      @(negedge clk);
      if (busy || done) busy_ok = 1'b0;
      chk(busy_ok, "R12 busy/done framing", 64'(busy_ok), 64'd1);
      chk(wr_cnt - wr0 == exp_wr, {tag, " write count"}, 64'(wr_cnt - wr0), 64'(exp_wr));
      chk(fetch_cnt - fe0 == exp_fetch, {tag, " fetch count"}, 64'(fetch_cnt - fe0),
          64'(exp_fetch));
      bad = 0;
      for (int a = 0; a < NT; a++)
         for (int b = 0; b < ME; b++)
            if (tbl[a][b] !== exp_t[a][b]) bad++;
      chk(bad == 0, {tag, " table contents"}, 64'(bad), 64'd0);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      for (int a = 0; a < NT; a++)
         for (int b = 0; b < ME; b++) begin
            tbl[a][b] = '0; exp_t[a][b] = '0;
         end
      repeat (3) @(negedge clk);
      // R1: state held by reset
      chk(!busy && !done, "R1 busy/done in reset", {62'd0, busy, done}, 64'd0);
      chk(status == 1'b1, "R1 status in reset", 64'(status), 64'd1);
      chk(!tw_en && !mem_req, "R1 no write or fetch", {62'd0, tw_en, mem_req}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && status, "R1 after release", {61'd0, busy, done, status}, 64'd1);

      // R2: single puts over every index, address low bits set
      for (int i = 0; i < ME; i++)
         run(0, 32'h10, 64'(i * 4096 + ((i * 389) & 12'hFFF)),
             64'hABCD_0000_0000_0000 | 64'(i << 12) | 64'(i & 3), 0, "R2");
      // R3: beyond the end, and below the base of table 1
      run(0, 32'h10, 64'(16 * 4096), 64'h1111, 0, "R3");
      run(0, 32'h10, 64'(40 * 4096 + 7), 64'h2222, 0, "R3");
      run(0, 32'h22, 64'h0000_0000_000F_F000, 64'h3333, 0, "R3");
      // R4: identifier that matches nothing
      run(0, 32'h33, 64'h0, 64'h4444, 0, "R4");
      run(1, 32'h33, 64'h0, 64'h0, 0, "R4");
      run(2, 32'h33, 64'h0, 64'h5555, 2, "R4");
      run(3, 32'h33, 64'h0, 64'h3000, 2, "R4");
      // R5: read every entry back, then a few misses that must hold get_data
      for (int i = 0; i < 18; i++)
         run(1, 32'h10, 64'(i * 4096 + 5), 64'h0, 0, "R5");
      run(1, 32'h10, 64'h0000_0000_0000_3000, 64'h0, 0, "R5");
      run(1, 32'h10, 64'h0000_0000_0004_0000, 64'h0, 0, "R5");
      // R11: table 1 with nonzero base
      for (int k = 0; k < 10; k++)
         run(0, 32'h22, 64'h0010_0000 + 64'(k * 4096 + 3), 64'hBEEF_0000_0000_0000 | 64'(k),
             0, "R11");
      for (int k = 0; k < 10; k++)
         run(1, 32'h22, 64'h0010_0000 + 64'(k * 4096), 64'h0, 0, "R11");
      // R6: stuff runs that fit
      run(2, 32'h10, 64'h0, 64'h5100_0000_0000_0001, 1, "R6");
      run(2, 32'h10, 64'(5 * 4096), 64'h5200_0000_0000_0002, 3, "R6");
      run(2, 32'h10, 64'(9 * 4096 + 12), 64'h5300_0000_0000_0003, 7, "R6");
      run(2, 32'h10, 64'h0, 64'h5400_0000_0000_0000, 16, "R6");
      run(2, 32'h22, 64'h0010_0000, 64'h5500_0000_0000_0003, 8, "R6");
      // R7: stuff counts rejected up front
      run(2, 32'h10, 64'h0, 64'h7000, 0, "R7");
      run(2, 32'h10, 64'h0, 64'h7001, 17, "R7");
      run(2, 32'h22, 64'h0010_0000, 64'h7002, 9, "R7");
      // R8: runs that cross the end of a table
      run(2, 32'h10, 64'(13 * 4096), 64'h8800_0000_0000_0002, 8, "R8");
      run(2, 32'h22, 64'h0010_7000, 64'h8900_0000_0000_0001, 4, "R8");
      run(3, 32'h22, 64'h0010_6000, 64'h0000_0000_0002_0000, 512, "R8");
      // R9: list copies from memory
      run(3, 32'h10, 64'(2 * 4096), 64'h0000_0000_0000_3000, 5, "R9");
      run(3, 32'h10, 64'h0, 64'h0000_0000_0007_F000, 16, "R9");
      run(3, 32'h22, 64'h0010_0000, 64'h0000_0001_0000_1000, 1, "R9");
      // R10: list commands rejected before any fetch
      run(3, 32'h10, 64'h0, 64'h3000, 0, "R10");
      run(3, 32'h10, 64'h0, 64'h3000, 513, "R10");
      run(3, 32'h10, 64'h0, 64'h3004, 2, "R10");
      run(3, 32'h10, 64'h0, 64'h3800, 2, "R10");
      run(3, 32'h10, 64'h0, 64'h3000, 600, "R10");
      finish_run();
   end

endmodule